// File: doc/BRIEF.md
# Flash Write Strobe Sequencer

This block sits between a synchronous host and an asynchronous parallel NOR flash bus. The host hands over one write at a time as an address, a data word and a strobe-order choice, using a valid/ready handshake. The block then drives the chip-enable group, the write strobe, the output enable, the address bus and the data bus. It does this so that every minimum setup, hold, pulse-width and recovery time of the flash write cycle is met. Each time limit is a parameter in nanoseconds. Elaboration turns it into a whole number of clock cycles, rounding up, from a clock-period parameter.

After each write pulse the block ignores the device's ready/busy status for the worst-case time the device may take to report busy. It then polls the status until the device reports ready. If the device stays busy longer than a configurable number of cycles, the block raises an error pulse and gives control back. After its own reset is released, the block holds the bus quiet for the flash reset-recovery time. A host read request may turn on the output enable only outside write activity, and only after the write-to-read recovery time has elapsed.

Top module: `flash_wr_gen`

## Requirements
- R1: After rst_ni is released, req_ready_o stays low and every strobe stays deasserted for RST_CYC-1 further clock samples, where RST_CYC = ceil(T_RST_NS/CLK_PERIOD_NS) (250 at 4 ns). The first write strobe therefore cannot assert until at least T_RST_NS after release.
- R2: A request is accepted on the rising edge where req_valid_i and req_ready_o are both high. req_ready_o is high only in idle. It stays low from acceptance until the pulse, the recovery time and the status wait have all completed.
- R3: flash_ce_o carries the 3-bit pattern CE_ON when the device is enabled and its bitwise inverse otherwise. All three bits switch together and no other value appears.
- R4: With req_mode_i=0, chip enable asserts one cycle before the write strobe. flash_we_no is then low for PULSE_CYC = max(ceil(T_WP_NS/P), ceil(T_SU_NS/P)-1) cycles (18 at 4 ns). Chip enable stays asserted for HOLD_CYC = ceil(T_CEH_NS/P) cycles (3) after flash_we_no rises.
- R5: With req_mode_i=1 the roles swap. flash_we_no asserts one cycle early, chip enable forms the PULSE_CYC-cycle pulse, and flash_we_no stays low HOLD_CYC cycles after chip enable deasserts.
- R6: flash_addr_o and flash_dq_o present the accepted address and data from the first strobe edge through the end of the hold phase, unchanged. flash_dq_oe_o is high during exactly that span.
- R7: req_ready_o returns no sooner than POST_CYC+1 clock samples after the pulse ends, whatever sts_i does. POST_CYC = max of ceil(T_BUSY_NS/P), ceil(T_WPH_NS/P), ceil(T_REC_NS/P) and HOLD_CYC+1, which is 23 at 4 ns. sts_i=1 means ready.
- R8: If sts_i is low when polling starts, the block waits. Idle is entered on the edge where sts_i is first seen high.
- R9: If sts_i stays low for TIMEOUT_CYC polling cycles, err_o pulses high for one cycle and the block returns to idle. A ready status seen on the last polling edge wins over the timeout.
- R10: flash_oe_no goes low one cycle after oe_req_i is high while no write is active. After a pulse ends, it first goes low REC_CYC+1 samples later, where REC_CYC = ceil(T_REC_NS/P) (9).
- R11: When a request is accepted while oe_req_i is high, flash_oe_no is driven high on the same edge that asserts the first strobe. It is never low while the data bus is driven.
- R12: flash_oe_no stays high throughout the reset-recovery wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host write request valid |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_addr_i | input | AW | Write address |
| req_data_i | input | DW | Write data |
| req_mode_i | input | 1 | 0: write strobe forms the pulse, 1: chip enable forms the pulse |
| oe_req_i | input | 1 | Host asks for the output enable |
| sts_i | input | 1 | Device status, 1 ready, 0 busy |
| err_o | output | 1 | One-cycle pulse on status timeout |
| flash_ce_o | output | 3 | Chip-enable group, CE_ON when enabled |
| flash_we_no | output | 1 | Write strobe, active low |
| flash_oe_no | output | 1 | Output enable, active low |
| flash_addr_o | output | AW | Flash address bus |
| flash_dq_o | output | DW | Flash data bus value |
| flash_dq_oe_o | output | 1 | Data bus drive enable |

## Verification
Two functions can fall on the same clock edge in this block. The first pair is write acceptance and an output-enable request. The bench holds oe_req_i high across an accepted request and expects flash_oe_no to be high on the first strobe sample. It then expects the enable back exactly REC_CYC+1 samples after the pulse ends. The second pair is the status going ready and the poll timeout expiring. The bench releases busy so that sts_i is first seen on the final polling edge, expecting a clean return. It then releases one cycle later, expecting err_o and the timeout-bounded ready time.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  typedef enum logic [2:0] {
    S_RST, S_IDLE, S_LEAD, S_PULSE, S_TAIL, S_WAIT, S_POLL
  } fwc_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fwc_cnt.sv
module fwc_cnt #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= RST_VAL;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fwc_seq.sv
module fwc_seq
  import fwc_pkg::*;
#(
  parameter int unsigned RST_CYC   = 250,
  parameter int unsigned PULSE_CYC = 18,
  parameter int unsigned HOLD_CYC  = 3,
  parameter int unsigned POST_CYC  = 23,
  parameter int unsigned TO_CYC    = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_mode_i,
  input  logic sts_i,
  output logic ready_o,
  output logic accept_o,
  output logic lead_o,
  output logic pulse_o,
  output logic mode_o,
  output logic err_o,
  output logic block_oe_o
);
  localparam int unsigned CMAX = umax(umax(RST_CYC, TO_CYC), umax(PULSE_CYC, POST_CYC));
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] RST_LD   = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] WAIT_LD  = CW'(POST_CYC - HOLD_CYC - 1);
  localparam logic [CW-1:0] TO_LD    = CW'(TO_CYC - 1);
  localparam logic [CW-1:0] PULSE_N  = CW'(PULSE_CYC);
  localparam logic [CW-1:0] POST_N   = CW'(POST_CYC);

  fwc_state_e      state_q, state_d;
  logic            ld, cnt_zero, err_d;
  logic [CW-1:0]   ld_val;
  logic            lead_q, pulse_q, mode_q, err_q;

  fwc_cnt #(.W(CW), .RST_VAL(RST_LD)) u_phase_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .zero_o (cnt_zero)
  );

  assign ready_o  = (state_q == S_IDLE);
  assign accept_o = ready_o & req_valid_i;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    err_d   = 1'b0;
    unique case (state_q)
      S_RST:   if (cnt_zero) state_d = S_IDLE;
      S_IDLE:  if (req_valid_i) state_d = S_LEAD;
      S_LEAD:  begin state_d = S_PULSE; ld = 1'b1; ld_val = PULSE_LD; end
      S_PULSE: if (cnt_zero) begin state_d = S_TAIL; ld = 1'b1; ld_val = HOLD_LD; end
      S_TAIL:  if (cnt_zero) begin state_d = S_WAIT; ld = 1'b1; ld_val = WAIT_LD; end
      S_WAIT:  if (cnt_zero) begin state_d = S_POLL; ld = 1'b1; ld_val = TO_LD; end
      S_POLL: begin
        if (sts_i) state_d = S_IDLE;           // ready beats timeout on the same edge
        else if (cnt_zero) begin state_d = S_IDLE; err_d = 1'b1; end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RST;
      lead_q  <= 1'b0;
      pulse_q <= 1'b0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lead_q  <= state_d inside {S_LEAD, S_PULSE, S_TAIL};
      pulse_q <= (state_d == S_PULSE);
      err_q   <= err_d;
      if (accept_o) mode_q <= req_mode_i;
    end
  end

  assign lead_o     = lead_q;
  assign pulse_o    = pulse_q;
  assign mode_o     = mode_q;
  assign err_o      = err_q;
  assign block_oe_o = state_d inside {S_RST, S_LEAD, S_PULSE, S_TAIL};

  // checker counters
  logic [CW-1:0] pw_q, post_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q   <= '0;
      post_q <= '1;
    end else begin
      pw_q   <= pulse_q ? ((pw_q != '1) ? pw_q + 1'b1 : pw_q) : '0;
      post_q <= pulse_q ? '0 : ((post_q != '1) ? post_q + 1'b1 : post_q);
    end
  end

  a_r4_lead_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(lead_q));
  a_r4_lead_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_q) |-> lead_q);
  a_r4_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_q) |-> pw_q >= PULSE_N);
  a_r2_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !lead_q && !pulse_q);
  a_r7_post_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> post_q >= POST_N);
  a_r9_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q);
endmodule

// File: rtl/fwc_oe_gate.sv
module fwc_oe_gate
  import fwc_pkg::*;
#(
  parameter int unsigned REC_CYC = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_req_i,
  input  logic block_i,
  input  logic pulse_i,
  input  logic lead_i,
  output logic oe_no
);
  localparam int unsigned RW = $clog2(umax(REC_CYC, 1) + 1);
  localparam logic [RW-1:0] REC_LD = RW'(REC_CYC);

  logic rec_zero, oe_act_q;

  // reloads while the pulse is active, runs out REC_CYC cycles after it ends
  fwc_cnt #(.W(RW), .RST_VAL('0)) u_rec_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pulse_i),
    .val_i  (REC_LD),
    .zero_o (rec_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_act_q <= 1'b0;
    else         oe_act_q <= oe_req_i && !block_i && rec_zero;
  end

  assign oe_no = !oe_act_q;

  a_r11_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_act_q |-> !lead_i && !pulse_i);
  a_r10_oe_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_i) |=> !oe_act_q);
endmodule

// File: rtl/flash_wr_gen.sv
module flash_wr_gen
  import fwc_pkg::*;
#(
  parameter int unsigned AW            = 23,
  parameter int unsigned DW            = 16,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_WP_NS       = 70,
  parameter int unsigned T_WPH_NS      = 30,
  parameter int unsigned T_SU_NS       = 50,
  parameter int unsigned T_CEH_NS      = 10,
  parameter int unsigned T_RST_NS      = 1000,
  parameter int unsigned T_REC_NS      = 35,
  parameter int unsigned T_BUSY_NS     = 90,
  parameter int unsigned TIMEOUT_CYC   = 64,
  parameter logic [2:0]  CE_ON         = 3'b100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          req_mode_i,
  input  logic          oe_req_i,
  input  logic          sts_i,
  output logic          err_o,
  output logic [2:0]    flash_ce_o,
  output logic          flash_we_no,
  output logic          flash_oe_no,
  output logic [AW-1:0] flash_addr_o,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe_o
);
  localparam int unsigned P         = CLK_PERIOD_NS;
  localparam int unsigned PULSE_CYC = umax(umax(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_SU_NS, P) - 1), 1);
  localparam int unsigned HOLD_CYC  = umax(ns_to_cyc(T_CEH_NS, P), 1);
  localparam int unsigned POST_CYC  = umax(umax(ns_to_cyc(T_BUSY_NS, P), ns_to_cyc(T_WPH_NS, P)),
                                           umax(ns_to_cyc(T_REC_NS, P), HOLD_CYC + 1));
  localparam int unsigned RST_CYC   = umax(ns_to_cyc(T_RST_NS, P), 1);
  localparam int unsigned REC_CYC   = ns_to_cyc(T_REC_NS, P);
  localparam int unsigned TO_CYC    = umax(TIMEOUT_CYC, 1);

  logic accept, lead, pulse, mode, block_oe;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dq_q;

  fwc_seq #(
    .RST_CYC(RST_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
    .POST_CYC(POST_CYC), .TO_CYC(TO_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_mode_i (req_mode_i),
    .sts_i      (sts_i),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .lead_o     (lead),
    .pulse_o    (pulse),
    .mode_o     (mode),
    .err_o      (err_o),
    .block_oe_o (block_oe)
  );

  fwc_oe_gate #(.REC_CYC(REC_CYC)) u_oe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_req_i(oe_req_i),
    .block_i (block_oe),
    .pulse_i (pulse),
    .lead_i  (lead),
    .oe_no   (flash_oe_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dq_q   <= '0;
    end else if (accept) begin
      addr_q <= req_addr_i;
      dq_q   <= req_data_i;
    end
  end

  // mode only changes on accept, while both strobes are off
  logic ce_act, we_act;
  assign ce_act        = mode ? pulse : lead;
  assign we_act        = mode ? lead  : pulse;
  assign flash_ce_o    = ce_act ? CE_ON : ~CE_ON;
  assign flash_we_no   = !we_act;
  assign flash_addr_o  = addr_q;
  assign flash_dq_o    = dq_q;
  assign flash_dq_oe_o = lead;

  a_r6_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead && $past(lead) |-> $stable(flash_addr_o) && $stable(flash_dq_o));
  a_r11_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> !flash_dq_oe_o);
  a_r1_quiet_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lead) |-> $past(req_ready_o));
endmodule

// File: tb/flash_wr_gen_tb.sv
`timescale 1ns/1ps
module flash_wr_gen_tb;
  localparam int AW = 23, DW = 16, P = 4, TO = 64;
  localparam logic [2:0] CE_ON = 3'b100;
  // expected cycle counts derived from the requirements
  localparam int PW   = ((70 + P - 1) / P > (50 + P - 1) / P - 1) ? (70 + P - 1) / P : (50 + P - 1) / P - 1;
  localparam int HOLD = (10 + P - 1) / P;
  localparam int POST = (90 + P - 1) / P;
  localparam int RSTC = (1000 + P - 1) / P;
  localparam int REC  = (35 + P - 1) / P;
  localparam int TLIM = POST + TO;

  logic clk = 0, rst_ni = 0;
  logic req_valid_i = 0, req_mode_i = 0, oe_req_i = 0, sts_i = 1;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_data_i = '0;
  logic req_ready_o, err_o, flash_we_no, flash_oe_no, flash_dq_oe_o;
  logic [2:0] flash_ce_o;
  logic [AW-1:0] flash_addr_o;
  logic [DW-1:0] flash_dq_o;

  always #2 clk = ~clk;

  flash_wr_gen #(.AW(AW), .DW(DW), .CLK_PERIOD_NS(P), .TIMEOUT_CYC(TO), .CE_ON(CE_ON)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_data_i(req_data_i), .req_mode_i(req_mode_i),
    .oe_req_i(oe_req_i), .sts_i(sts_i), .err_o(err_o), .flash_ce_o(flash_ce_o),
    .flash_we_no(flash_we_no), .flash_oe_no(flash_oe_no), .flash_addr_o(flash_addr_o),
    .flash_dq_o(flash_dq_o), .flash_dq_oe_o(flash_dq_oe_o));

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    bit mode;
    int busy;
    bit oe;
  } item_t;

  item_t sb_q[$];
  int checks = 0, errors = 0, mon_done = 0;
  bit fin = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ce_on();
    return flash_ce_o == CE_ON;
  endfunction
  function automatic bit pon(input bit m);
    return m ? ce_on() : !flash_we_no;
  endfunction
  function automatic bit lon(input bit m);
    return m ? !flash_we_no : ce_on();
  endfunction

  // monitor: pops the scoreboard at the first strobe and measures the cycle
  initial begin
    forever begin
      @(negedge clk);
      if (fin) break;
      if (ce_on() || !flash_we_no) begin
        item_t it;
        int pre, width, hold, k, oe_first;
        bit bad_bus, bad_ce, bad_lead, err_seen;
        string rq;
        if (sb_q.size() == 0) begin
          check(0, "R2 unexpected strobe", 1, 0);
          continue;
        end
        it = sb_q.pop_front();
        rq = it.mode ? "R5" : "R4";
        if (it.oe) check(flash_oe_no == 1'b1, "R11 oe off at first strobe", flash_oe_no, 1);
        pre = 0; bad_ce = 0;
        while (!pon(it.mode)) begin
          if (lon(it.mode)) pre++;
          if (flash_ce_o != CE_ON && flash_ce_o != ~CE_ON) bad_ce = 1;
          @(negedge clk);
        end
        check(pre == 1, {rq, " lead strobe cycles"}, pre, 1);
        check(flash_addr_o == it.addr && flash_dq_o == it.data && flash_dq_oe_o,
              "R6 bus value at pulse", flash_addr_o, it.addr);
        width = 0; bad_bus = 0; bad_lead = 0;
        while (pon(it.mode)) begin
          width++;
          if (flash_addr_o != it.addr || flash_dq_o != it.data || !flash_dq_oe_o) bad_bus = 1;
          if (!lon(it.mode)) bad_lead = 1;
          if (flash_ce_o != CE_ON && flash_ce_o != ~CE_ON) bad_ce = 1;
          @(negedge clk);
        end
        check(width == PW, {rq, " pulse width"}, width, PW);
        check(!bad_lead, {rq, " lead held during pulse"}, bad_lead, 0);
        if (it.busy > 0) sts_i = 1'b0;
        k = 0; hold = 0; oe_first = -1; err_seen = 0;
        while (!req_ready_o && k < 400) begin
          if (lon(it.mode)) begin
            hold++;
            if (flash_addr_o != it.addr || flash_dq_o != it.data || !flash_dq_oe_o) bad_bus = 1;
          end
          if (flash_ce_o != CE_ON && flash_ce_o != ~CE_ON) bad_ce = 1;
          if (!flash_oe_no && oe_first < 0) oe_first = k;
          if (err_o) err_seen = 1;
          if (it.busy > 0 && k == it.busy - 1) sts_i = 1'b1;
          k++;
          @(negedge clk);
        end
        if (err_o) err_seen = 1;
        check(hold == HOLD, {rq, " strobe hold after pulse"}, hold, HOLD);
        check(!bad_bus, "R6 bus stable through hold", bad_bus, 0);
        check(!bad_ce, "R3 chip-enable code", bad_ce, 0);
        begin
          int exp_k;
          bit exp_err;
          exp_err = it.busy > TLIM;
          if (it.busy <= POST + 1) exp_k = POST + 1;
          else if (it.busy <= TLIM) exp_k = it.busy;
          else exp_k = TLIM;
          check(k == exp_k, it.busy > TLIM ? "R9 ready after timeout" :
                (it.busy > POST + 1 ? "R8 ready on status" : "R7 ready after busy window"),
                k, exp_k);
          check(err_seen == exp_err, "R9 error flag", err_seen, exp_err);
          check(oe_first == (it.oe ? REC + 1 : -1), "R10 oe after write recovery",
                oe_first, it.oe ? REC + 1 : -1);
        end
        sts_i = 1'b1;
        mon_done++;
      end
    end
  end

  // driver: pushes the expected item, then issues the request
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit m, input int busy, input bit oe);
    item_t it;
    int tgt;
    it.addr = a; it.data = d; it.mode = m; it.busy = busy; it.oe = oe;
    while (!req_ready_o) @(negedge clk);
    if (oe) begin
      oe_req_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(flash_oe_no == 1'b0, "R10 oe in idle", flash_oe_no, 0);
    end
    tgt = mon_done + 1;
    sb_q.push_back(it);
    req_addr_i = a; req_data_i = d; req_mode_i = m; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(req_ready_o == 1'b0, "R2 ready drops on accept", req_ready_o, 0);
    wait (mon_done == tgt);
    oe_req_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    bit bad_oe, bad_str;
    oe_req_i = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready_o == 1'b0 && flash_we_no && flash_ce_o == ~CE_ON, "R1 reset state",
          req_ready_o, 0);
    check(flash_oe_no == 1'b1, "R12 oe off in reset", flash_oe_no, 1);
    rst_ni = 1'b1;
    n = 0; bad_oe = 0; bad_str = 0;
    do begin
      @(negedge clk);
      if (!req_ready_o) begin
        n++;
        if (!flash_oe_no) bad_oe = 1;
        if (!flash_we_no || flash_ce_o != ~CE_ON) bad_str = 1;
      end
    end while (!req_ready_o && n < 2000);
    check(n == RSTC - 1, "R1 reset recovery length", n, RSTC - 1);
    check(!bad_str, "R1 strobes quiet in recovery", bad_str, 0);
    check(!bad_oe, "R12 oe held off in recovery", bad_oe, 0);
    check(flash_oe_no == 1'b0, "R10 oe once idle", flash_oe_no, 0);
    oe_req_i = 1'b0;
    @(negedge clk);
    check(flash_oe_no == 1'b1, "R10 oe released", flash_oe_no, 1);

    do_write(23'h1234a5, 16'hbeef, 1'b0, 0, 1'b0);      // R4 / R7
    do_write(23'h7fffff, 16'h0001, 1'b1, 40, 1'b0);     // R5 / R8
    do_write(23'h000000, 16'hffff, 1'b0, 10, 1'b1);     // R11 / R10, busy inside window
    do_write(23'h2aaaaa, 16'h5555, 1'b0, 100, 1'b0);    // R9 timeout
    do_write(23'h155555, 16'haaaa, 1'b1, TLIM, 1'b1);   // R9 boundary: ready wins
    do_write(23'h0f0f0f, 16'h1234, 1'b0, TLIM + 1, 1'b0); // R9 boundary: timeout
    do_write(23'h000001, 16'h8000, 1'b1, POST + 2, 1'b0);  // R8 just past window
    check(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule